// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a 16-bit logical address issued by a small processor core into a 20-bit physical address. The upper nibble of the logical address is compared against two boundary nibbles packed into one programmable size register. That comparison places the access in one of three windows. The low window passes through unchanged. The middle window is relocated by a data offset. The top window is relocated by a stack offset. Each offset is counted in 4 KiB pages.

The two offsets and the size register sit behind a byte-wide internal I/O port, and all three can be read back. The translation path is purely combinational from the logical address and the current register contents. A register write is captured on the clock edge, so it changes the translation only from the following cycle.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset, all three registers read back as 0x00, and every logical address maps to itself zero-extended to 20 bits.
- R2: A write to I/O address 0x12 loads the data offset. Reading address 0x12 returns the full 8-bit value last written.
- R3: A write to I/O address 0x13 loads the size register. Reading address 0x13 returns the full 8-bit value. Bits 3:0 are the low boundary and bits 7:4 are the high boundary.
- R4: A write to I/O address 0x11 loads the stack offset. Reading address 0x11 returns the full 8-bit value.
- R5: When logical bits 15:12 are below the low boundary, phys_addr equals the logical address zero-extended.
- R6: When logical bits 15:12 are at or above the low boundary and below the high boundary, phys_addr is (logical + data_offset × 4096) mod 2^20.
- R7: When logical bits 15:12 are at or above both boundaries, phys_addr is (logical + stack_offset × 4096) mod 2^20.
- R8: A nibble equal to the low boundary selects the data window when the high boundary is larger. A nibble equal to the high boundary selects the stack window.
- R9: Writes to any other I/O address change no register, and reads of any other I/O address return 0x00.
- R10: In the cycle a write is presented, phys_addr still reflects the old register value. The new value applies from the cycle after the clock edge.
- R11: When the high boundary is at or below the low boundary, no data window exists. Nibbles below the low boundary pass through, and all others use the stack offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 8 | Internal I/O register address |
| io_wr | input | 1 | Write strobe, captured at the rising edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Combinational read-back of the addressed register |
| log_addr | input | 16 | Logical address from the core |
| phys_addr | output | 20 | Translated physical address |

## Verification
The checker keeps a shadow copy of the three registers, built only from port writes. On every cycle it checks read-back for every address and checks that phys_addr matches the window rule for the current nibble. This covers the low, data and stack windows as well as unmapped reads. Some behaviours only the bench scenarios can show: the window overlap case, the exact boundary nibbles, carry out of bit 19 being dropped, and a write becoming visible only after its clock edge. The bench covers these with directed cases and with seeded random traffic.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    // Window chosen for one logical access
    typedef enum logic [1:0] {
        WIN_PASS  = 2'd0,
        WIN_DATA  = 2'd1,
        WIN_STACK = 2'd2
    } win_e;

endpackage

// File: rtl/seg_xlate_regs.sv
module seg_xlate_regs #(
    parameter int REG_W  = 8,
    parameter int OFF_W  = 8,
    parameter int IO_AW  = 8,
    parameter logic [IO_AW-1:0] ADDR_STK = 8'h11,
    parameter logic [IO_AW-1:0] ADDR_DAT = 8'h12,
    parameter logic [IO_AW-1:0] ADDR_SIZ = 8'h13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IO_AW-1:0] io_addr,
    input  logic             io_wr,
    input  logic [REG_W-1:0] io_wdata,
    output logic [REG_W-1:0] io_rdata,
    output logic [OFF_W-1:0] stk_off,
    output logic [OFF_W-1:0] dat_off,
    output logic [REG_W-1:0] siz_val
);

    typedef struct packed {
        logic [OFF_W-1:0] stk;
        logic [OFF_W-1:0] dat;
        logic [REG_W-1:0] siz;
    } regs_t;

    regs_t r_d, r_q;
    logic [OFF_W-1:0] wr_off;
    logic [REG_W-1:0] stk_rd, dat_rd;

    // Offset load: low REG_W bits from the bus, anything above cleared
    generate
        if (OFF_W > REG_W) begin : g_wide
            assign wr_off = {{(OFF_W-REG_W){1'b0}}, io_wdata};
            assign stk_rd = r_q.stk[REG_W-1:0];
            assign dat_rd = r_q.dat[REG_W-1:0];
        end else if (OFF_W == REG_W) begin : g_same
            assign wr_off = io_wdata;
            assign stk_rd = r_q.stk;
            assign dat_rd = r_q.dat;
        end else begin : g_narrow
            assign wr_off = io_wdata[OFF_W-1:0];
            assign stk_rd = {{(REG_W-OFF_W){1'b0}}, r_q.stk};
            assign dat_rd = {{(REG_W-OFF_W){1'b0}}, r_q.dat};
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (io_wr) begin
            unique case (io_addr)
                ADDR_STK: r_d.stk = wr_off;
                ADDR_DAT: r_d.dat = wr_off;
                ADDR_SIZ: r_d.siz = io_wdata;
                default:  r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (io_addr)
            ADDR_STK: io_rdata = stk_rd;
            ADDR_DAT: io_rdata = dat_rd;
            ADDR_SIZ: io_rdata = r_q.siz;
            default:  io_rdata = '0;
        endcase
    end

    assign stk_off = r_q.stk;
    assign dat_off = r_q.dat;
    assign siz_val = r_q.siz;

endmodule

// File: rtl/seg_xlate_window.sv
module seg_xlate_window
    import seg_xlate_pkg::*;
#(
    parameter int LOG_W = 16,
    parameter int NIB_W = 4,
    parameter int REG_W = 8,
    parameter int OFF_W = 8
) (
    input  logic [LOG_W-1:0] log_addr,
    input  logic [REG_W-1:0] siz_val,
    input  logic [OFF_W-1:0] stk_off,
    input  logic [OFF_W-1:0] dat_off,
    output win_e             win,
    output logic [OFF_W-1:0] sel_off
);

    logic [NIB_W-1:0] nib, lo_bnd, hi_bnd;

    assign nib    = log_addr[LOG_W-1 -: NIB_W];
    assign lo_bnd = siz_val[NIB_W-1:0];
    assign hi_bnd = siz_val[2*NIB_W-1 -: NIB_W];

    // Pass window has priority, then data, stack otherwise
    always_comb begin
        if (nib < lo_bnd) begin
            win     = WIN_PASS;
            sel_off = '0;
        end else if (nib < hi_bnd) begin
            win     = WIN_DATA;
            sel_off = dat_off;
        end else begin
            win     = WIN_STACK;
            sel_off = stk_off;
        end
    end

endmodule

// File: rtl/seg_xlate_add.sv
module seg_xlate_add
    import seg_xlate_pkg::*;
#(
    parameter int LOG_W  = 16,
    parameter int PHYS_W = 20,
    parameter int OFF_W  = 8,
    parameter int PAGE_SH = 12
) (
    input  logic [LOG_W-1:0]  log_addr,
    input  win_e              win,
    input  logic [OFF_W-1:0]  sel_off,
    output logic [PHYS_W-1:0] phys_addr
);

    logic [PHYS_W-1:0] base_ext, off_ext;

    assign base_ext = PHYS_W'(log_addr);
    assign off_ext  = PHYS_W'(sel_off) << PAGE_SH;

    always_comb begin
        if (win == WIN_PASS) begin
            phys_addr = base_ext;
        end else begin
            phys_addr = base_ext + off_ext;
        end
    end

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int LOG_W  = 16,
    parameter int PHYS_W = 20,
    parameter int NIB_W  = 4,
    parameter int REG_W  = 8,
    parameter int IO_AW  = 8,
    parameter logic [IO_AW-1:0] ADDR_STK = 8'h11,
    parameter logic [IO_AW-1:0] ADDR_DAT = 8'h12,
    parameter logic [IO_AW-1:0] ADDR_SIZ = 8'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              io_wr,
    input  logic [REG_W-1:0]  io_wdata,
    output logic [REG_W-1:0]  io_rdata,
    input  logic [LOG_W-1:0]  log_addr,
    output logic [PHYS_W-1:0] phys_addr
);

    localparam int PAGE_SH = LOG_W - NIB_W;
    localparam int OFF_W   = PHYS_W - PAGE_SH;

    logic [OFF_W-1:0] stk_off, dat_off, sel_off;
    logic [REG_W-1:0] siz_val;
    win_e             win;

    seg_xlate_regs #(
        .REG_W(REG_W), .OFF_W(OFF_W), .IO_AW(IO_AW),
        .ADDR_STK(ADDR_STK), .ADDR_DAT(ADDR_DAT), .ADDR_SIZ(ADDR_SIZ)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .stk_off(stk_off), .dat_off(dat_off), .siz_val(siz_val)
    );

    seg_xlate_window #(
        .LOG_W(LOG_W), .NIB_W(NIB_W), .REG_W(REG_W), .OFF_W(OFF_W)
    ) win_i (
        .log_addr(log_addr), .siz_val(siz_val), .stk_off(stk_off),
        .dat_off(dat_off), .win(win), .sel_off(sel_off)
    );

    seg_xlate_add #(
        .LOG_W(LOG_W), .PHYS_W(PHYS_W), .OFF_W(OFF_W), .PAGE_SH(PAGE_SH)
    ) add_i (
        .log_addr(log_addr), .win(win), .sel_off(sel_off),
        .phys_addr(phys_addr)
    );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int LOG_W  = 16,
    parameter int PHYS_W = 20,
    parameter int NIB_W  = 4,
    parameter int REG_W  = 8,
    parameter int IO_AW  = 8,
    parameter logic [IO_AW-1:0] ADDR_STK = 8'h11,
    parameter logic [IO_AW-1:0] ADDR_DAT = 8'h12,
    parameter logic [IO_AW-1:0] ADDR_SIZ = 8'h13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IO_AW-1:0]  io_addr,
    input logic              io_wr,
    input logic [REG_W-1:0]  io_wdata,
    input logic [REG_W-1:0]  io_rdata,
    input logic [LOG_W-1:0]  log_addr,
    input logic [PHYS_W-1:0] phys_addr
);

    localparam int PAGE_SH = LOG_W - NIB_W;

    // Shadow of the register file, built only from port traffic
    logic [REG_W-1:0] sh_stk, sh_dat, sh_siz;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_stk <= '0;
            sh_dat <= '0;
            sh_siz <= '0;
        end else if (io_wr) begin
            if (io_addr == ADDR_STK) sh_stk <= io_wdata;
            if (io_addr == ADDR_DAT) sh_dat <= io_wdata;
            if (io_addr == ADDR_SIZ) sh_siz <= io_wdata;
        end
    end

    logic [NIB_W-1:0]  nib, lo_b, hi_b;
    logic [PHYS_W-1:0] ext, via_dat, via_stk;
    assign nib     = log_addr[LOG_W-1 -: NIB_W];
    assign lo_b    = sh_siz[NIB_W-1:0];
    assign hi_b    = sh_siz[2*NIB_W-1 -: NIB_W];
    assign ext     = PHYS_W'(log_addr);
    assign via_dat = ext + (PHYS_W'(sh_dat) << PAGE_SH);
    assign via_stk = ext + (PHYS_W'(sh_stk) << PAGE_SH);

    p_rd_dat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == ADDR_DAT) |-> (io_rdata == sh_dat));
    p_rd_siz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == ADDR_SIZ) |-> (io_rdata == sh_siz));
    p_rd_stk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == ADDR_STK) |-> (io_rdata == sh_stk));
    p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nib < lo_b) |-> (phys_addr == ext));
    p_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (nib >= lo_b && nib < hi_b) |-> (phys_addr == via_dat));
    p_stack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nib >= lo_b && nib >= hi_b) |-> (phys_addr == via_stk));
    p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr != ADDR_STK && io_addr != ADDR_DAT && io_addr != ADDR_SIZ)
        |-> (io_rdata == '0));

endmodule

bind seg_xlate_top seg_xlate_chk #(
    .LOG_W(LOG_W), .PHYS_W(PHYS_W), .NIB_W(NIB_W), .REG_W(REG_W),
    .IO_AW(IO_AW), .ADDR_STK(ADDR_STK), .ADDR_DAT(ADDR_DAT), .ADDR_SIZ(ADDR_SIZ)
) chk_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .log_addr(log_addr),
    .phys_addr(phys_addr)
);

// File: tb/seg_xlate_top_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  io_addr = 8'h00;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [15:0] log_addr = 16'h0000;
    logic [19:0] phys_addr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_stk = 8'h00, m_dat = 8'h00, m_siz = 8'h00;

    always #2 clk = ~clk;

    seg_xlate_top dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .log_addr(log_addr),
        .phys_addr(phys_addr)
    );

    function automatic logic [19:0] exp_phys(input logic [15:0] la,
        input logic [7:0] stk, input logic [7:0] dat, input logic [7:0] siz);
        logic [3:0] n;
        n = la[15:12];
        if (n < siz[3:0])      return {4'h0, la};
        else if (n < siz[7:4]) return {4'h0, la} + {dat, 12'h000};
        else                   return {4'h0, la} + {stk, 12'h000};
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h11:   return m_stk;
            8'h12:   return m_dat;
            8'h13:   return m_siz;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wr = 1'b1; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
        case (a)
            8'h11: m_stk = d;
            8'h12: m_dat = d;
            8'h13: m_siz = d;
            default: ;
        endcase
    endtask

    task automatic rd(input string req, input logic [7:0] a);
        io_addr = a;
        #1;
        check(req, {24'h0, io_rdata}, {24'h0, exp_rd(a)});
    endtask

    task automatic xl(input string req, input logic [15:0] la);
        log_addr = la;
        #1;
        check(req, {12'h0, phys_addr}, {12'h0, exp_phys(la, m_stk, m_dat, m_siz)});
    endtask

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        #7 rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd("R1", 8'h11); rd("R1", 8'h12); rd("R1", 8'h13);
        xl("R1", 16'hF123); xl("R1", 16'h0ABC);

        // R2, R3, R4: load and read back
        wr(8'h12, 8'hA5); rd("R2", 8'h12);
        wr(8'h13, 8'h93); rd("R3", 8'h13);
        wr(8'h11, 8'h3C); rd("R4", 8'h11);

        // Windows with low=3, high=9
        xl("R5", 16'h2FFF);
        xl("R6", 16'h5123);
        xl("R7", 16'hC456);
        // R8: exact boundary nibbles
        xl("R8", 16'h3000);
        xl("R8", 16'h9000);
        xl("R8", 16'h8FFF);

        // R6 and R7: carry beyond bit 19 dropped
        wr(8'h12, 8'hFF); wr(8'h11, 8'hF8);
        xl("R6", 16'h8FFF);
        xl("R7", 16'hFFFF);

        // R9: writes elsewhere change nothing, reads elsewhere are zero
        wr(8'h10, 8'h77); wr(8'h14, 8'h55); wr(8'h92, 8'h11);
        rd("R9", 8'h11); rd("R9", 8'h12); rd("R9", 8'h13);
        rd("R9", 8'h10); rd("R9", 8'h14); rd("R9", 8'hFF);
        xl("R9", 16'h5000);

        // R11: high boundary below low boundary -> no data window
        wr(8'h13, 8'h35);
        xl("R11", 16'h2ABC);
        xl("R11", 16'h4ABC);
        xl("R11", 16'h5ABC);
        wr(8'h13, 8'h66);
        xl("R11", 16'h6001);
        xl("R11", 16'h5001);

        // R10: write visible only after its clock edge
        wr(8'h13, 8'h82);
        @(negedge clk);
        log_addr = 16'h4321;
        io_addr = 8'h12; io_wdata = 8'h40; io_wr = 1'b1;
        #1;
        check("R10", {12'h0, phys_addr}, {12'h0, exp_phys(16'h4321, m_stk, m_dat, m_siz)});
        @(negedge clk);
        io_wr = 1'b0;
        m_dat = 8'h40;
        xl("R10", 16'h4321);

        // Random traffic
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            a = 8'h10 + 8'($urandom_range(0, 4));
            if ($urandom_range(0, 2) == 0) wr(a, 8'($urandom));
            rd("R9", a);
            xl("R6", 16'($urandom));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule